// File: doc/BRIEF.md
# External Bus Idle-Cycle Sequencer

This block runs external bus accesses one at a time. A requester holds an address, a direction flag and write data steady with a valid flag. The sequencer then steps the bus through its states and drives one chip select per address area, a read strobe, a write strobe and the output enable of the data bus. The requester learns that the access has finished through a ready flag, which is raised in the last state of the access. Read data is latched at the end of that same state.

The sequencer remembers the direction and the area of the access that has just finished. Some devices release the data bus slowly after a read. When an access of that kind is followed directly by a read of another area, or by any write, the sequencer puts one quiet idle state in front of the new access, so that two drivers never meet on the data bus. Each hazard has its own enable bit, and both bits come up set after reset. The read-to-read case also requires the mode input to select wide (advanced) addressing. Each area is set up independently as a two-state or a three-state area.

Top module: `ext_bus_idle_seq`

## Requirements
- R1: After reset every chip select is high (inactive), the read strobe and the write strobe are high, the data output enable is low, read data is zero, and both idle-enable bits are 1.
- R2: The area is `reqAddr[ADDR_W-1 -: 3]`. During an access, exactly the chip select `csN[area]` is low. At all other times no more than one chip select is low.
- R3: An area whose `areaThreeState` bit is 1 takes three states (T1, T2, T3). An area whose bit is 0 takes two states (T1, T2). `reqReady` is high only in the final state.
- R4: If a read starts in the state right after a read to a different area finished, one idle state is inserted, provided the read-idle enable is 1 and `modeAdvanced` is 1.
- R5: If a write starts in the state right after a read finished, one idle state is inserted, provided the write-idle enable is 1, whatever the value of `modeAdvanced`.
- R6: No idle state is inserted for a read to the same area as the read just finished, for any access after a write, or when the bus had no access in the previous state.
- R7: When `modeAdvanced` is 0, back-to-back reads to different areas get no idle state.
- R8: An inserted idle state lasts exactly one state and comes before T1. During that state all chip selects, the read strobe and the write strobe are high, and the output enable is low.
- R9: On a read, `rdData` takes the value of `busDin` at the clock edge that ends the final state.
- R10: On a read, the read strobe is low in every T state and the output enable stays low. On a write, the output enable is high in every T state with `busDout` equal to `reqWdata`, the write strobe is low from T2 through the final state, and the read strobe stays high.
- R11: When `cfgLoad` is high at a clock edge, the read-idle and write-idle enables take the values of `cfgRdIdleEn` and `cfgWrIdleEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request present; held until ready |
| reqReady | output | 1 | High in the final state of the access |
| reqAddr | input | ADDR_W | Access address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | DATA_W | Write data |
| modeAdvanced | input | 1 | 1 selects wide addressing mode |
| areaThreeState | input | NUM_AREAS | Per area: 1 = three-state access, 0 = two-state |
| cfgLoad | input | 1 | Loads both idle-enable bits |
| cfgRdIdleEn | input | 1 | New read-after-read idle enable |
| cfgWrIdleEn | input | 1 | New write-after-read idle enable |
| busAddr | output | ADDR_W | External address |
| busDout | output | DATA_W | External write data |
| busDin | input | DATA_W | External read data |
| dataOe | output | 1 | Data bus output enable |
| csN | output | NUM_AREAS | Active-low chip selects |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| rdData | output | DATA_W | Captured read data |

## Verification
The bench runs chains of back-to-back accesses that cover every pairing: read then read to another area, read then read to the same area, read then write, write then read, and write then write. It repeats these with a one-state gap, with mode 0, and with each enable cleared. A design that ignored the previous area would add idle states between reads to the same area. A design that did not check whether the bus was idle would add an idle state after a gap. Per-cycle strobe checks catch an idle state that still drives a chip select or the data bus, and a write strobe that goes low already in T1. Access lengths are counted up to ready, so a two-state area run with three states, or an idle state longer than one state, shows up as a wrong count.

// File: rtl/ebis_pkg.sv
package ebis_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_TI, PH_T1, PH_T2, PH_T3} phase_e;
  typedef enum logic [1:0] {S_IDLE, S_T1, S_T2, S_T3} state_e;
  typedef struct packed {
    logic csEn;
    logic rdEn;
    logic wrEn;
    logic oeEn;
    logic finish;
  } strobe_t;
endpackage

// File: rtl/ebis_ctrl.sv
module ebis_ctrl
  import ebis_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    hazard,
  input  logic    isThree,
  output strobe_t strb,
  output logic    reqReady
);
  state_e st, stNext;
  phase_e phase;
  logic   lastState;

  always_comb begin
    case (st)
      S_IDLE:  phase = !reqValid ? PH_IDLE : (hazard ? PH_TI : PH_T1);
      S_T1:    phase = PH_T1;
      S_T2:    phase = PH_T2;
      default: phase = PH_T3;
    endcase
  end

  assign lastState = (phase == PH_T3) || (phase == PH_T2 && !isThree);

  always_comb begin
    case (phase)
      PH_TI:   stNext = S_T1;
      PH_T1:   stNext = S_T2;
      PH_T2:   stNext = lastState ? S_IDLE : S_T3;
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    strb.csEn   = (phase == PH_T1) || (phase == PH_T2) || (phase == PH_T3);
    strb.rdEn   = strb.csEn && !reqWrite;
    strb.wrEn   = ((phase == PH_T2) || (phase == PH_T3)) && reqWrite;
    strb.oeEn   = strb.csEn && reqWrite;
    strb.finish = lastState;
  end

  assign reqReady = lastState;

  // R8: an idle state is followed directly by T1
  assert_idle_then_t1_R8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_TI) |=> (phase == PH_T1));

  // R3: a three-state area continues from T2 into T3
  assert_three_state_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_T2 && isThree) |=> (phase == PH_T3));

  // R3: after ready the sequencer is back at the decision state
  assert_ready_then_free_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> (st == S_IDLE));
endmodule

// File: rtl/ebis_dp.sv
module ebis_dp
  import ebis_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int AREA_BITS = 3,
  localparam int NUM_AREAS = 1 << AREA_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 reqWrite,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic                 modeAdvanced,
  input  logic [NUM_AREAS-1:0] areaThreeState,
  input  logic                 cfgLoad,
  input  logic                 cfgRdIdleEn,
  input  logic                 cfgWrIdleEn,
  input  logic [DATA_W-1:0]    busDin,
  output logic                 hazard,
  output logic                 isThree,
  output logic [NUM_AREAS-1:0] csN,
  output logic                 rdN,
  output logic                 wrN,
  output logic                 dataOe,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [DATA_W-1:0]    busDout,
  output logic [DATA_W-1:0]    rdData
);
  logic [AREA_BITS-1:0] area, prevArea;
  logic prevWrite, prevFresh, rdIdleEn, wrIdleEn;
  logic rdRdHazard, wrRdHazard;

  assign area    = reqAddr[ADDR_W-1 -: AREA_BITS];
  assign isThree = areaThreeState[area];

  assign rdRdHazard = !prevWrite && !reqWrite && (area != prevArea) && rdIdleEn && modeAdvanced;
  assign wrRdHazard = !prevWrite && reqWrite && wrIdleEn;
  assign hazard     = prevFresh && reqValid && (rdRdHazard || wrRdHazard);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdleEn <= 1'b1;
      wrIdleEn <= 1'b1;
    end else if (cfgLoad) begin
      rdIdleEn <= cfgRdIdleEn;
      wrIdleEn <= cfgWrIdleEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevFresh <= 1'b0;
      prevWrite <= 1'b0;
      prevArea  <= '0;
      rdData    <= '0;
    end else begin
      prevFresh <= strb.finish;
      if (strb.finish) begin
        prevWrite <= reqWrite;
        prevArea  <= area;
        if (!reqWrite) rdData <= busDin;
      end
    end
  end

  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_cs
    assign csN[a] = !(strb.csEn && (area == AREA_BITS'(a)));
  end

  assign rdN     = !strb.rdEn;
  assign wrN     = !strb.wrEn;
  assign dataOe  = strb.oeEn;
  assign busAddr = reqAddr;
  assign busDout = reqWdata;

  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (&csN) |-> (rdN && wrN && !dataOe));

  assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdN || wrN));

  assert_read_capture_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && strb.finish) |=> (rdData == $past(busDin)));
endmodule

// File: rtl/ext_bus_idle_seq.sv
module ext_bus_idle_seq
  import ebis_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int AREA_BITS = 3,
  localparam int NUM_AREAS = 1 << AREA_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 reqWrite,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic                 modeAdvanced,
  input  logic [NUM_AREAS-1:0] areaThreeState,
  input  logic                 cfgLoad,
  input  logic                 cfgRdIdleEn,
  input  logic                 cfgWrIdleEn,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [DATA_W-1:0]    busDout,
  input  logic [DATA_W-1:0]    busDin,
  output logic                 dataOe,
  output logic [NUM_AREAS-1:0] csN,
  output logic                 rdN,
  output logic                 wrN,
  output logic [DATA_W-1:0]    rdData
);
  strobe_t strb;
  logic    hazard, isThree;

  ebis_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .hazard(hazard), .isThree(isThree), .strb(strb), .reqReady(reqReady)
  );

  ebis_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AREA_BITS(AREA_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .modeAdvanced(modeAdvanced), .areaThreeState(areaThreeState),
    .cfgLoad(cfgLoad), .cfgRdIdleEn(cfgRdIdleEn), .cfgWrIdleEn(cfgWrIdleEn),
    .busDin(busDin), .hazard(hazard), .isThree(isThree), .csN(csN),
    .rdN(rdN), .wrN(wrN), .dataOe(dataOe), .busAddr(busAddr),
    .busDout(busDout), .rdData(rdData)
  );
endmodule

// File: tb/ext_bus_idle_seq_bench.sv
module ext_bus_idle_seq_bench;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int NUM_AREAS = 8;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, modeAdvanced = 1'b1;
  logic cfgLoad = 1'b0, cfgRdIdleEn = 1'b1, cfgWrIdleEn = 1'b1;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [NUM_AREAS-1:0] areaThreeState = 8'b0000_0101;
  logic reqReady, dataOe, rdN, wrN;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busDout, busDin, rdData;
  logic [NUM_AREAS-1:0] csN;

  always #(CLK_P/2) clk = ~clk;
  assign busDin = busAddr[DATA_W-1:0] ^ 16'h5A5A;

  ext_bus_idle_seq u_ext_bus_idle_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .modeAdvanced(modeAdvanced), .areaThreeState(areaThreeState),
    .cfgLoad(cfgLoad), .cfgRdIdleEn(cfgRdIdleEn), .cfgWrIdleEn(cfgWrIdleEn),
    .busAddr(busAddr), .busDout(busDout), .busDin(busDin), .dataOe(dataOe),
    .csN(csN), .rdN(rdN), .wrN(wrN), .rdData(rdData)
  );

  typedef struct {
    int lat;
    int idle;
    bit wr;
    int area;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] rdExp;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit bFresh = 0, bPrevWr = 0, bRdEn = 1, bWrEn = 1;
  int bPrevArea = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic doReq(input logic [ADDR_W-1:0] a, input bit wr,
                       input logic [DATA_W-1:0] d, input string tag);
    exp_t e;
    int ar = int'(a[ADDR_W-1 -: 3]);
    bit rr = !bPrevWr && !wr && (ar != bPrevArea) && bRdEn && modeAdvanced;
    bit wa = !bPrevWr && wr && bWrEn;
    e.idle = (bFresh && (rr || wa)) ? 1 : 0;
    e.lat  = e.idle + (areaThreeState[ar] ? 3 : 2);
    e.wr = wr; e.area = ar; e.data = d; e.tag = tag;
    e.rdExp = a[DATA_W-1:0] ^ 16'h5A5A;
    q.push_back(e);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; reqWdata = d;
    #1;
    while (!reqReady) begin @(negedge clk); #1; end
    @(negedge clk);
    bFresh = 1; bPrevWr = wr; bPrevArea = ar;
  endtask

  task automatic gap(input int n);
    reqValid = 1'b0;
    bFresh = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic loadCfg(input bit r, input bit w);
    cfgLoad = 1'b1; cfgRdIdleEn = r; cfgWrIdleEn = w;
    @(negedge clk);
    cfgLoad = 1'b0; bRdEn = r; bWrEn = w;
    @(negedge clk);
  endtask

  // monitor: pops expected items as each access completes
  initial begin
    int cyc, idl, k;
    bit pend;
    logic [DATA_W-1:0] pexp;
    string ptag;
    exp_t e;
    cyc = 0; idl = 0; pend = 0; pexp = '0; ptag = "";
    forever begin
      @(negedge clk); #2;
      if (pend) begin
        chk(rdData == pexp, ptag, "R9 rdData", rdData, pexp);
        pend = 0;
      end
      if (rstN && reqValid && q.size() > 0) begin
        e = q[0];
        if (&csN) begin
          idl++;
          chk(rdN && wrN && !dataOe, e.tag, "R8 idle strobes", {rdN, wrN, dataOe}, 3'b110);
          chk(cyc == 0, e.tag, "R8 idle before T1", cyc, 0);
        end else begin
          k = cyc - idl;
          chk(csN == ~(8'b1 << e.area), e.tag, "R2 chip select", csN, ~(8'b1 << e.area));
          if (e.wr)
            chk(dataOe && rdN && (wrN == (k == 0)) && busDout == e.data, e.tag,
                "R10 write strobes", {dataOe, rdN, wrN}, {2'b11, k == 0});
          else
            chk(!rdN && wrN && !dataOe, e.tag, "R10 read strobes", {dataOe, rdN, wrN}, 3'b001);
        end
        cyc++;
        if (reqReady) begin
          chk(cyc == e.lat, e.tag, "R3 states to ready", cyc, e.lat);
          chk(idl == e.idle, e.tag, "idle count", idl, e.idle);
          if (!e.wr) begin pend = 1; pexp = e.rdExp; ptag = e.tag; end
          void'(q.pop_front());
          cyc = 0; idl = 0;
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(&csN && rdN && wrN && !dataOe && !reqReady, "R1", "reset strobes",
        {csN, rdN, wrN, dataOe}, {8'hFF, 3'b110});
    chk(rdData == '0, "R1", "reset rdData", rdData, 0);

    // default enables (R1) with wide mode
    doReq(24'h000100, 0, '0, "R6 first after idle");
    doReq(24'h200200, 0, '0, "R4 read area change");
    doReq(24'h200204, 0, '0, "R6 same area read");
    doReq(24'h200208, 1, 16'hBEEF, "R5 write after read");
    doReq(24'h000110, 0, '0, "R6 read after write");
    doReq(24'h400300, 1, 16'h1234, "R5 write after read 3st");
    doReq(24'h400304, 1, 16'h4321, "R6 write after write");
    gap(3);
    doReq(24'h400310, 0, '0, "R6 read after gap");
    gap(1);
    doReq(24'h200220, 0, '0, "R6 read after one gap");

    gap(2);
    modeAdvanced = 1'b0;
    doReq(24'h000120, 0, '0, "R7 first");
    doReq(24'h200230, 0, '0, "R7 no idle short mode");
    doReq(24'h200234, 1, 16'hA55A, "R5 write short mode");
    gap(2);
    modeAdvanced = 1'b1;

    loadCfg(0, 1);
    doReq(24'h000130, 0, '0, "R11 first");
    doReq(24'h400320, 0, '0, "R11 read idle off");
    doReq(24'h400324, 1, 16'h0F0F, "R11 write idle on");
    gap(2);
    loadCfg(1, 0);
    doReq(24'h200240, 0, '0, "R11 first b");
    doReq(24'h200244, 1, 16'hF0F0, "R11 write idle off");
    doReq(24'h000140, 0, '0, "R6 read after write b");
    doReq(24'h400330, 0, '0, "R4 read idle back on");
    gap(3);

    chk(q.size() == 0, "R3", "all accesses completed", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule